// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital sequencer for a 12-bit successive-approximation converter. Software picks one of eight analog inputs with a 4-bit channel field and a conversion-clock divider, then pulses a trigger. The block latches both choices and drives the latched channel number to an external analog multiplexer. It then counts out a fixed setup phase on the divided clock and resolves the result one bit at a time, most significant bit first. For each bit it drives a trial code to an external DAC and reads a single comparator bit back.

When the last bit is decided, the result goes into a high and a low data register. A completion flag is set and a one-cycle interrupt pulse is raised. The analog multiplexer, DAC, comparator and sample-and-hold are outside the block. Software must pick a divider that keeps the total conversion time above the converter's analog minimum of 7.5 µs. The block does not check this.

The controller has four states. IDLE waits for a valid trigger. SETUP counts the setup conversion clocks. BITS runs the bit trials. STORE is a single cycle that loads the result. The transitions are:

- IDLE to SETUP: a trigger arrives with a channel code from 0 to 7.
- SETUP to BITS: the twelfth setup tick.
- BITS to BITS: the fourth tick of any step except the last one.
- BITS to STORE: the fourth tick of the step for bit 0.
- STORE to IDLE: always, after one cycle.

Top module: `sar_seq`

## Requirements
- R1: After reset, mux_sel, dac_code, data_hi, data_lo, done_flag and irq are all 0.
- R2: A trigger accepted in IDLE latches chan_sel[2:0] onto mux_sel on the same clock edge. Later changes to chan_sel have no effect until the next accepted trigger.
- R3: A trigger whose chan_sel is 8 to 15 is ignored. No conversion starts and every output keeps its value.
- R4: The conversion clock ticks once every 2 << div_sel system clocks, so div_sel values 0, 1, 2 and 3 give division by 2, 4, 8 and 16. The divider setting is latched at start and the divider count restarts at the start edge. With R as the ratio, irq rises 60·R + 1 system clocks after the start edge.
- R5: The setup phase lasts 12 conversion clocks, with dac_code at 0. Then 12 bit steps of 4 conversion clocks each follow, for bits 11 down to 0. The trial bit of a step is set from the first system clock of that step. cmp_in is sampled at the last system clock of the step's fourth conversion clock. The bit is kept when cmp_in is 1, meaning the input is at or above the trial level. At the start of the first step, dac_code reads 0x800.
- R6: The result is loaded one system clock after the last bit decision. data_hi gets {4'b0, result[11:8]} and data_lo gets result[7:0], both on the same edge. The data registers change at no other time. dac_code holds the final result afterwards.
- R7: done_flag clears on the start edge, stays 0 for the whole conversion, rises on the load edge, and stays 1 until the next accepted trigger.
- R8: irq is high for exactly one system clock, on the cycle in which done_flag rises.
- R9: A trigger that arrives while a conversion is running, or during the load cycle, is ignored. A trigger sampled on the first edge after the load cycle starts a new conversion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig | input | 1 | Software conversion trigger, sampled each clock |
| chan_sel | input | 4 | Channel code; 0 to 7 are valid, 8 to 15 are reserved |
| div_sel | input | 2 | Conversion-clock divider select (ratio 2 << div_sel) |
| cmp_in | input | 1 | Comparator: 1 when the input is at or above the DAC level |
| mux_sel | output | 3 | Latched channel number for the analog multiplexer |
| dac_code | output | 12 | Trial code driven to the DAC |
| data_hi | output | 8 | Result bits [11:8], zero-extended |
| data_lo | output | 8 | Result bits [7:0] |
| done_flag | output | 1 | Conversion-complete status |
| irq | output | 1 | One-cycle completion interrupt pulse |

## Verification
A wrong step or setup count shifts every later dac_code transition. The reference model sees this on the first system clock where a trial bit appears early or late, and at the latest when irq arrives off its 60·R + 1 cycle position. A wrong keep-or-drop decision shows as a bad dac_code at the start of the next bit step, well before the final result is loaded. A stuck or late state (for example STORE not left, or a reserved or mid-run trigger accepted) shows at once in done_flag or mux_sel, which the model compares on every cycle.

// File: rtl/sar_pkg.sv
package sar_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETUP,
        ST_BITS,
        ST_STORE
    } sar_state_e;

endpackage

// File: rtl/sar_prescale.sv
module sar_prescale #(
    parameter int DIV_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             run,
    input  logic [DIV_W-1:0] div_sel,
    output logic             tick
);
    localparam int PRE_W = 1 << DIV_W;

    logic [DIV_W-1:0] sel_q;
    logic [PRE_W-1:0] pre_cnt;
    logic [PRE_W-1:0] limit;
    logic [PRE_W:0]   span;

    always_comb begin
        span  = ({{PRE_W{1'b0}}, 1'b1} << sel_q) << 1;
        limit = span[PRE_W-1:0] - PRE_W'(1);
    end

    assign tick = run && (pre_cnt == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q   <= '0;
            pre_cnt <= '0;
        end else if (restart) begin
            sel_q   <= div_sel;
            pre_cnt <= '0;
        end else if (run) begin
            if (pre_cnt == limit) begin
                pre_cnt <= '0;
            end else begin
                pre_cnt <= pre_cnt + PRE_W'(1);
            end
        end
    end

endmodule

// File: rtl/sar_fsm.sv
module sar_fsm
    import sar_pkg::*;
#(
    parameter int RES_W     = 12,
    parameter int SEL_W     = 4,
    parameter int CH_N      = 8,
    parameter int SETUP_CYC = 12,
    parameter int STEP_CYC  = 4,
    localparam int CH_W     = $clog2(CH_N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig,
    input  logic [SEL_W-1:0] chan_sel,
    input  logic             tick,
    input  logic             cmp_in,
    output logic             start,
    output logic             busy,
    output logic             load,
    output logic [CH_W-1:0]  mux_sel,
    output logic [RES_W-1:0] code
);
    localparam int CNT_W = (SETUP_CYC > STEP_CYC) ? $clog2(SETUP_CYC) : $clog2(STEP_CYC);
    localparam logic [CNT_W-1:0] SETUP_LAST = CNT_W'(SETUP_CYC - 1);
    localparam logic [CNT_W-1:0] STEP_LAST  = CNT_W'(STEP_CYC - 1);
    localparam logic [RES_W-1:0] TOP_BIT    = {1'b1, {(RES_W-1){1'b0}}};

    sar_state_e       state, state_nx;
    logic [CNT_W-1:0] cnt;
    logic [RES_W-1:0] mask;
    logic             chan_ok;
    logic             setup_end;
    logic             step_end;

    assign chan_ok   = (chan_sel < SEL_W'(CH_N));
    assign start     = (state == ST_IDLE) && trig && chan_ok;
    assign busy      = (state == ST_SETUP) || (state == ST_BITS);
    assign load      = (state == ST_STORE);
    assign setup_end = tick && (cnt == SETUP_LAST);
    assign step_end  = tick && (cnt == STEP_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start) state_nx = ST_SETUP;
            ST_SETUP: if (setup_end) state_nx = ST_BITS;
            ST_BITS:  if (step_end && mask[0]) state_nx = ST_STORE;
            ST_STORE: state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            mask    <= TOP_BIT;
            code    <= '0;
            mux_sel <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        mux_sel <= chan_sel[CH_W-1:0];
                        code    <= '0;
                        cnt     <= '0;
                        mask    <= TOP_BIT;
                    end
                end
                ST_SETUP: begin
                    if (setup_end) begin
                        cnt  <= '0;
                        code <= mask;
                    end else if (tick) begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                ST_BITS: begin
                    if (step_end) begin
                        cnt  <= '0;
                        mask <= mask >> 1;
                        code <= (cmp_in ? code : (code & ~mask)) | (mask >> 1);
                    end else if (tick) begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                ST_STORE: begin
                    cnt <= '0;
                end
                default: begin
                    cnt <= '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/sar_result.sv
module sar_result #(
    parameter int RES_W = 12,
    parameter int HI_W  = 8,
    parameter int LO_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             load,
    input  logic [RES_W-1:0] code,
    output logic [HI_W-1:0]  data_hi,
    output logic [LO_W-1:0]  data_lo,
    output logic             done_flag,
    output logic             irq
);
    localparam int HI_USED = RES_W - LO_W;
    localparam int HI_PAD  = HI_W - HI_USED;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_hi   <= '0;
            data_lo   <= '0;
            done_flag <= 1'b0;
            irq       <= 1'b0;
        end else begin
            irq <= load;
            if (load) begin
                data_hi   <= {{HI_PAD{1'b0}}, code[RES_W-1:LO_W]};
                data_lo   <= code[LO_W-1:0];
                done_flag <= 1'b1;
            end else if (start) begin
                done_flag <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/sar_seq.sv
module sar_seq #(
    parameter int RES_W     = 12,
    parameter int SEL_W     = 4,
    parameter int CH_N      = 8,
    parameter int DIV_W     = 2,
    parameter int SETUP_CYC = 12,
    parameter int STEP_CYC  = 4,
    parameter int HI_W      = 8,
    parameter int LO_W      = 8,
    localparam int CH_W     = $clog2(CH_N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig,
    input  logic [SEL_W-1:0] chan_sel,
    input  logic [DIV_W-1:0] div_sel,
    input  logic             cmp_in,
    output logic [CH_W-1:0]  mux_sel,
    output logic [RES_W-1:0] dac_code,
    output logic [HI_W-1:0]  data_hi,
    output logic [LO_W-1:0]  data_lo,
    output logic             done_flag,
    output logic             irq
);
    logic start;
    logic busy;
    logic load;
    logic tick;

    sar_prescale #(
        .DIV_W (DIV_W)
    ) u_prescale (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (start),
        .run     (busy),
        .div_sel (div_sel),
        .tick    (tick)
    );

    sar_fsm #(
        .RES_W     (RES_W),
        .SEL_W     (SEL_W),
        .CH_N      (CH_N),
        .SETUP_CYC (SETUP_CYC),
        .STEP_CYC  (STEP_CYC)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig     (trig),
        .chan_sel (chan_sel),
        .tick     (tick),
        .cmp_in   (cmp_in),
        .start    (start),
        .busy     (busy),
        .load     (load),
        .mux_sel  (mux_sel),
        .code     (dac_code)
    );

    sar_result #(
        .RES_W (RES_W),
        .HI_W  (HI_W),
        .LO_W  (LO_W)
    ) u_result (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .load      (load),
        .code      (dac_code),
        .data_hi   (data_hi),
        .data_lo   (data_lo),
        .done_flag (done_flag),
        .irq       (irq)
    );

endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
    parameter int RES_W = 12,
    parameter int SEL_W = 4,
    parameter int CH_N  = 8,
    parameter int HI_W  = 8,
    parameter int LO_W  = 8,
    localparam int CH_W = $clog2(CH_N)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             trig,
    input logic [SEL_W-1:0] chan_sel,
    input logic             busy,
    input logic [CH_W-1:0]  mux_sel,
    input logic [RES_W-1:0] dac_code,
    input logic [HI_W-1:0]  data_hi,
    input logic [LO_W-1:0]  data_lo,
    input logic             done_flag,
    input logic             irq
);
    localparam int HI_USED = RES_W - LO_W;

    a_r8_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    a_r8_irq_with_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> done_flag);

    a_r7_flag_low_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !done_flag);

    a_r6_data_only_on_load: assert property (@(posedge clk) disable iff (!rst_n)
        !irq |-> ($stable(data_hi) && $stable(data_lo)));

    a_r6_hi_zero_extended: assert property (@(posedge clk) disable iff (!rst_n)
        (data_hi >> HI_USED) == '0);

    a_r2_channel_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(mux_sel));

    a_r5_setup_code_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (dac_code == '0));

    a_r3_reserved_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !irq && trig && (chan_sel >= SEL_W'(CH_N))) |=> !busy);

endmodule

bind sar_seq sar_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .trig      (trig),
    .chan_sel  (chan_sel),
    .busy      (busy),
    .mux_sel   (mux_sel),
    .dac_code  (dac_code),
    .data_hi   (data_hi),
    .data_lo   (data_lo),
    .done_flag (done_flag),
    .irq       (irq)
);

// File: tb/sar_seq_bench.sv
module sar_seq_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trig = 1'b0;
    logic [3:0]  chan_sel = 4'd0;
    logic [1:0]  div_sel = 2'd0;
    logic        cmp_in;
    logic [2:0]  mux_sel;
    logic [11:0] dac_code;
    logic [7:0]  data_hi;
    logic [7:0]  data_lo;
    logic        done_flag;
    logic        irq;

    logic [11:0] vin [8];

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    always #2 clk = ~clk;

    assign cmp_in = (vin[mux_sel] >= dac_code);

    sar_seq u_sar_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig      (trig),
        .chan_sel  (chan_sel),
        .div_sel   (div_sel),
        .cmp_in    (cmp_in),
        .mux_sel   (mux_sel),
        .dac_code  (dac_code),
        .data_hi   (data_hi),
        .data_lo   (data_lo),
        .done_flag (done_flag),
        .irq       (irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    function automatic logic [11:0] exp_code(input logic [11:0] v, input int s);
        logic [11:0] c = '0;
        logic [11:0] t;
        for (int i = 0; i < s; i++) begin
            t = c | (12'h800 >> i);
            if (v >= t) c = t;
        end
        return c | (12'h800 >> s);
    endfunction

    // behavioural reference model
    bit          m_act = 0;
    int          m_k = 0;
    int          m_r = 2;
    int          m_ch = 0;
    logic [11:0] m_dac = '0;
    logic [7:0]  m_hi = '0;
    logic [7:0]  m_lo = '0;
    logic        m_flag = 0;
    logic        m_irq = 0;
    logic [2:0]  m_mux = '0;

    always @(posedge clk) begin
        bit was_idle;
        if (!rst_n) begin
            m_act = 0; m_k = 0; m_dac = '0; m_hi = '0; m_lo = '0;
            m_flag = 0; m_irq = 0; m_mux = '0;
        end else begin
            was_idle = !m_act;
            m_irq = 0;
            if (m_act) begin
                m_k++;
                if (m_k < 12 * m_r) m_dac = '0;
                else if (m_k < 60 * m_r) m_dac = exp_code(vin[m_ch], (m_k - 12 * m_r) / (4 * m_r));
                else if (m_k == 60 * m_r) m_dac = vin[m_ch];
                else begin
                    m_hi = {4'b0, vin[m_ch][11:8]};
                    m_lo = vin[m_ch][7:0];
                    m_flag = 1; m_irq = 1; m_act = 0;
                end
            end
            if (was_idle && trig && chan_sel < 4'd8) begin
                m_act = 1; m_k = 0; m_ch = int'(chan_sel);
                m_mux = chan_sel[2:0]; m_r = 2 << div_sel;
                m_flag = 0; m_dac = '0;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            chk("R2 mux_sel", int'(mux_sel), int'(m_mux));
            chk("R5 dac_code", int'(dac_code), int'(m_dac));
            chk("R6 data_hi", int'(data_hi), int'(m_hi));
            chk("R6 data_lo", int'(data_lo), int'(m_lo));
            chk("R7 done_flag", int'(done_flag), int'(m_flag));
            chk("R8 irq", int'(irq), int'(m_irq));
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    // caller is at a negedge; returns at the negedge where irq is seen
    task automatic run_conv(input int ch, input int dv, input logic [11:0] v, input bit mid);
        int n;
        int r;
        r = 2 << dv;
        vin[ch] = v;
        chan_sel = 4'(ch);
        div_sel = 2'(dv);
        trig = 1'b1;
        @(negedge clk);
        trig = 1'b0;
        n = 0;
        chk("R7 flag cleared at start", int'(done_flag), 0);
        chk("R2 channel latched", int'(mux_sel), ch);
        while (!irq && n < 2000) begin
            @(negedge clk);
            n++;
            if (n == 12 * r) chk("R5 first trial 0x800", int'(dac_code), 12'h800);
            if (mid && n == 20) begin
                trig = 1'b1;
                chan_sel = 4'((ch + 3) % 8);
                div_sel = 2'(3 - dv);
            end
            if (mid && n == 22) trig = 1'b0;
        end
        chk(mid ? "R9 mid trigger ignored, timing" : "R4 irq at 60R+1", n, 60 * r + 1);
        chk("R6 result low", int'(data_lo), int'(v[7:0]));
        chk("R6 result high", int'(data_hi), int'(v[11:8]));
    endtask

    initial begin
        for (int i = 0; i < 8; i++) vin[i] = 12'(i * 300 + 17);
        repeat (3) @(negedge clk);
        chk("R1 reset mux_sel", int'(mux_sel), 0);
        chk("R1 reset dac_code", int'(dac_code), 0);
        chk("R1 reset data", int'({data_hi, data_lo}), 0);
        chk("R1 reset flag", int'(done_flag), 0);
        chk("R1 reset irq", int'(irq), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        run_conv(0, 0, 12'h000, 0);
        @(negedge clk);
        chk("R8 irq single cycle", int'(irq), 0);
        chk("R7 flag held", int'(done_flag), 1);
        repeat (3) @(negedge clk);
        run_conv(7, 1, 12'hFFF, 0);
        repeat (2) @(negedge clk);
        run_conv(3, 2, 12'h800, 0);
        repeat (2) @(negedge clk);
        run_conv(5, 3, 12'h7FF, 0);
        repeat (2) @(negedge clk);
        run_conv(1, 0, 12'hA5C, 1);
        chk("R2 channel kept after mid change", int'(mux_sel), 1);
        repeat (2) @(negedge clk);

        chan_sel = 4'd9;
        trig = 1'b1;
        @(negedge clk);
        trig = 1'b0;
        repeat (4) @(negedge clk);
        chk("R3 reserved code flag", int'(done_flag), 1);
        chk("R3 reserved code mux_sel", int'(mux_sel), 1);
        chk("R3 reserved code dac_code", int'(dac_code), 12'hA5C);
        chan_sel = 4'd15;
        trig = 1'b1;
        @(negedge clk);
        trig = 1'b0;
        @(negedge clk);
        chk("R3 code 15 flag", int'(done_flag), 1);

        @(negedge clk);
        run_conv(2, 2, 12'h001, 0);
        run_conv(6, 0, 12'h3C3, 0);
        chk("R9 back-to-back channel", int'(mux_sel), 6);
        repeat (2) @(negedge clk);
        run_conv(4, 1, 12'h555, 0);
        repeat (4) @(negedge clk);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule